// File: doc/BRIEF.md
# IR Carrier Frequency Meter

This block measures the carrier of a modulated infrared signal while the receiver is in its wideband (learning) mode. It samples the raw IR line once per pulse of a 2 MHz tick enable, so every count it reports is a multiple of 500 ns. For each carrier cycle it measures the time from one rising edge to the next, and the number of ticks the line stayed high after that edge. A programmable number of complete cycles is summed and divided to give an average. The average is then latched into two read-only result registers.

The period result carries a valid flag in its most significant bit, and the count sits below it. The high-time result uses the same tick units, and its top bit is always zero. Software sets the detect-enable bit, sets the cycle count through the configuration port, and reads the results. Converting ticks to frequency or duty cycle is left to software.

Top module: `ir_carrier_meter`

## Requirements
- R1: After reset the period result and the high-time result both read 0x00, and the cycle-count configuration register reads 0x63.
- R2: The IR line is sampled only on tick cycles. A rising edge is a tick sample of 1 that follows a tick sample of 0. The period of a cycle is the number of ticks from one rising edge to the next. The high time is the number of tick samples of 1 counted from the rising edge onward (the edge sample included), up to the next rising edge.
- R3: When the configuration holds N, the results are latched at the rising edge that completes N measured cycles. Each result is the sum of those N cycles divided by N, with the remainder discarded. The first rising edge after a restart only sets the time reference and is not measured.
- R4: A configuration value of 0 behaves exactly like 1.
- R5: A single cycle's period or high count that would exceed 127 ticks is held at 127.
- R6: On a latch, bit 7 of the period register is set and bits 6:0 hold the average period. A valid result never has a period of 0. The high-time register keeps bit 7 at 0, and its count never exceeds the period count.
- R7: A read strobe on the period register clears bit 7 on the next clock and leaves bits 6:0 unchanged. If a latch happens in the same cycle as the strobe, the latch wins and bit 7 stays set.
- R8: While detect-enable is low, both result registers hold their values and no latch occurs. The cycle accumulation and time reference are discarded, so measurement restarts at the first rising edge after re-enable.
- R9: A write to the configuration register discards any partly accumulated cycles and the time reference, in the same way as R8.
- R10: Changes on the IR line during cycles without a tick have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 2 MHz sampling enable, one clock wide |
| ir_i | input | 1 | Raw modulated IR input |
| det_en_i | input | 1 | Carrier detection enable |
| np_we_i | input | 1 | Write strobe for the cycle-count register |
| np_wdata_i | input | 8 | Cycle-count write data |
| np_q_o | output | 8 | Cycle-count register contents |
| rd_prd_i | input | 1 | Read strobe of the period register |
| prd_o | output | 8 | Bit 7 valid, bits 6:0 average period in ticks |
| hprd_o | output | 8 | Bits 6:0 average high time in ticks, bit 7 zero |

## Verification
The bench compares both result registers against a behavioural model on every clock. It then checks hand-computed results for several carriers: an exact single-cycle capture, a four-cycle average whose true value is fractional (so a design that rounds or averages the wrong cycles reads 12 instead of 11), the zero configuration, and a cycle far beyond 127 ticks that a design without saturation would wrap. The IR line is toggled between ticks, which catches a design that samples on every clock. A read strobe is held high across a latch, which catches a design that lets the clear win. Detect-enable is dropped, and the cycle count is rewritten partway through an accumulation; a design that kept its stale reference or partial sum would latch early with a mixed average such as 19 instead of 8.

// File: rtl/ir_cm_pkg.sv
package ir_cm_pkg;
   // Default widths of the meter
   localparam int unsigned DEF_CNT_W = 7;
   localparam int unsigned DEF_NP_W  = 8;

   // Per-tick edge information delivered to the cycle timer
   typedef struct packed {
      logic rise;   // tick sample 1 after tick sample 0
      logic hi;     // tick sample is 1
   } edge_info_t;
endpackage

// File: rtl/ir_cm_sync.sv
module ir_cm_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_flops
      logic [STAGES:0] chain;
      assign chain[0] = d_i;
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk_i) begin
            if (!rst_ni) chain[g+1] <= 1'b0;
            else         chain[g+1] <= chain[g];
         end
      end
      assign q_o = chain[STAGES];
   end
endmodule

// File: rtl/ir_cm_edge.sv
module ir_cm_edge
   import ir_cm_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       ir_i,
   output edge_info_t edge_o
);
   logic lvl_q;

   // Level is remembered only on tick cycles
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     lvl_q <= 1'b0;
      else if (tick_i) lvl_q <= ir_i;
   end

   assign edge_o.rise = tick_i & ir_i & ~lvl_q;
   assign edge_o.hi   = tick_i & ir_i;
endmodule

// File: rtl/ir_cm_timer.sv
module ir_cm_timer
   import ir_cm_pkg::*;
#(
   parameter int unsigned CNT_W = DEF_CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             clr_i,
   input  edge_info_t       edge_i,
   output logic             cyc_done_o,
   output logic [CNT_W-1:0] cyc_p_o,
   output logic [CNT_W-1:0] cyc_h_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             have_ref_q;
   logic [CNT_W-1:0] pcnt_q;
   logic [CNT_W-1:0] hcnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         have_ref_q <= 1'b0;
         pcnt_q     <= '0;
         hcnt_q     <= '0;
      end else if (edge_i.rise) begin
         have_ref_q <= 1'b1;
         pcnt_q     <= CNT_ONE;
         hcnt_q     <= CNT_ONE;
      end else if (tick_i) begin
         if (pcnt_q != CNT_MAX) pcnt_q <= pcnt_q + CNT_ONE;
         if (edge_i.hi && hcnt_q != CNT_MAX) hcnt_q <= hcnt_q + CNT_ONE;
      end
   end

   assign cyc_done_o = edge_i.rise & have_ref_q & ~clr_i;
   assign cyc_p_o    = pcnt_q;
   assign cyc_h_o    = hcnt_q;
endmodule

// File: rtl/ir_cm_avg.sv
module ir_cm_avg #(
   parameter int unsigned CNT_W = 7,
   parameter int unsigned NP_W  = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             cyc_done_i,
   input  logic [CNT_W-1:0] cyc_p_i,
   input  logic [CNT_W-1:0] cyc_h_i,
   input  logic [NP_W:0]    n_eff_i,
   input  logic             rd_i,
   output logic             lat_o,
   output logic             valid_o,
   output logic [CNT_W-1:0] prd_o,
   output logic [CNT_W-1:0] hprd_o
);
   localparam int unsigned SUM_W = CNT_W + NP_W;

   logic [SUM_W-1:0] sum_p_q, sum_h_q;
   logic [SUM_W-1:0] sum_p_nx, sum_h_nx, div;
   logic [NP_W-1:0]  ncyc_q;
   logic [NP_W:0]    ncyc_inc;
   logic             valid_q;
   logic [CNT_W-1:0] prd_q, hprd_q;

   assign sum_p_nx = sum_p_q + SUM_W'(cyc_p_i);
   assign sum_h_nx = sum_h_q + SUM_W'(cyc_h_i);
   assign ncyc_inc = {1'b0, ncyc_q} + {{NP_W{1'b0}}, 1'b1};
   assign div      = SUM_W'(n_eff_i);
   assign lat_o    = cyc_done_i & (ncyc_inc >= n_eff_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         sum_p_q <= '0;
         sum_h_q <= '0;
         ncyc_q  <= '0;
      end else if (lat_o) begin
         sum_p_q <= '0;
         sum_h_q <= '0;
         ncyc_q  <= '0;
      end else if (cyc_done_i) begin
         sum_p_q <= sum_p_nx;
         sum_h_q <= sum_h_nx;
         ncyc_q  <= ncyc_inc[NP_W-1:0];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prd_q  <= '0;
         hprd_q <= '0;
      end else if (lat_o) begin
         prd_q  <= CNT_W'(sum_p_nx / div);
         hprd_q <= CNT_W'(sum_h_nx / div);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    valid_q <= 1'b0;
      else if (lat_o) valid_q <= 1'b1;
      else if (rd_i)  valid_q <= 1'b0;
   end

   assign valid_o = valid_q;
   assign prd_o   = prd_q;
   assign hprd_o  = hprd_q;
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter
   import ir_cm_pkg::*;
#(
   parameter int unsigned   CNT_W       = DEF_CNT_W,
   parameter int unsigned   NP_W        = DEF_NP_W,
   parameter logic [NP_W-1:0] NP_RST    = NP_W'(8'h63),
   parameter int unsigned   SYNC_STAGES = 0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic            ir_i,
   input  logic            det_en_i,
   input  logic            np_we_i,
   input  logic [NP_W-1:0] np_wdata_i,
   output logic [NP_W-1:0] np_q_o,
   input  logic            rd_prd_i,
   output logic [CNT_W:0]  prd_o,
   output logic [CNT_W:0]  hprd_o
);
   if (CNT_W < 2 || CNT_W > 15) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..15");
   end
   if (NP_W < 1 || NP_W > 12) begin : g_bad_np_w
      $error("NP_W must lie in 1..12");
   end
   if (SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 3");
   end

   logic            ir_s;
   logic            clr_w;
   logic [NP_W-1:0] np_q;
   logic [NP_W:0]   n_eff;
   edge_info_t      edge_w;
   logic            cyc_done_w;
   logic [CNT_W-1:0] cyc_p_w, cyc_h_w;
   logic            lat_w;
   logic            valid_w;
   logic [CNT_W-1:0] prd_w, hprd_w;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      np_q <= NP_RST;
      else if (np_we_i) np_q <= np_wdata_i;
   end

   assign n_eff = (np_q == '0) ? {{NP_W{1'b0}}, 1'b1} : {1'b0, np_q};
   assign clr_w = ~det_en_i | np_we_i;

   ir_cm_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ir_i),
      .q_o   (ir_s)
   );

   ir_cm_edge edge_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .ir_i  (ir_s),
      .edge_o(edge_w)
   );

   ir_cm_timer #(.CNT_W(CNT_W)) timer_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .clr_i     (clr_w),
      .edge_i    (edge_w),
      .cyc_done_o(cyc_done_w),
      .cyc_p_o   (cyc_p_w),
      .cyc_h_o   (cyc_h_w)
   );

   ir_cm_avg #(.CNT_W(CNT_W), .NP_W(NP_W)) avg_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_w),
      .cyc_done_i(cyc_done_w),
      .cyc_p_i   (cyc_p_w),
      .cyc_h_i   (cyc_h_w),
      .n_eff_i   (n_eff),
      .rd_i      (rd_prd_i),
      .lat_o     (lat_w),
      .valid_o   (valid_w),
      .prd_o     (prd_w),
      .hprd_o    (hprd_w)
   );

   assign np_q_o = np_q;
   assign prd_o  = {valid_w, prd_w};
   assign hprd_o = {1'b0, hprd_w};
endmodule

// File: rtl/ir_carrier_meter_chk.sv
module ir_carrier_meter_chk #(
   parameter int unsigned CNT_W = 7
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           det_en_i,
   input logic           rd_prd_i,
   input logic           lat_w,
   input logic [CNT_W:0] prd_o,
   input logic [CNT_W:0] hprd_o
);
   a_r6_period_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prd_o[CNT_W] |-> (prd_o[CNT_W-1:0] != '0));

   a_r6_high_le_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prd_o[CNT_W] |-> (hprd_o[CNT_W-1:0] <= prd_o[CNT_W-1:0]));

   a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_prd_i && !lat_w) |=> !prd_o[CNT_W]);

   a_r7_latch_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_w |=> prd_o[CNT_W]);

   a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !det_en_i |=> ($stable(prd_o[CNT_W-1:0]) && $stable(hprd_o)));

   a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lat_w |=> ($stable(prd_o[CNT_W-1:0]) && $stable(hprd_o)));
endmodule

bind ir_carrier_meter ir_carrier_meter_chk #(.CNT_W(CNT_W)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .det_en_i(det_en_i),
   .rd_prd_i(rd_prd_i),
   .lat_w   (lat_w),
   .prd_o   (prd_o),
   .hprd_o  (hprd_o)
);

// File: tb/ir_carrier_meter_tb_top.sv
`timescale 1ns/100ps
module ir_carrier_meter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, ir = 1'b0, det_en = 1'b0;
   logic       np_we = 1'b0, rd_prd = 1'b0;
   logic [7:0] np_wdata = 8'h00;
   logic [7:0] np_q, prd, hprd;
   bit         glitch = 1'b0;
   bit         done = 1'b0;
   int         checks = 0, errors = 0;
   string      cur_req = "R1";

   always #2.5 clk = ~clk;

   ir_carrier_meter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ir_i(ir),
      .det_en_i(det_en), .np_we_i(np_we), .np_wdata_i(np_wdata),
      .np_q_o(np_q), .rd_prd_i(rd_prd), .prd_o(prd), .hprd_o(hprd)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: tick indices and queues of measured cycles
   int  m_tick, m_last, m_hi, m_prd, m_hprd, m_np;
   bit  m_prev, m_ref, m_val;
   int  pq[$], hq[$];

   always @(posedge clk) begin : model
      bit clr, lat;
      int neff, sp, sh;
      if (!rst_n) begin
         m_tick = 0; m_last = 0; m_hi = 0; m_prd = 0; m_hprd = 0; m_np = 'h63;
         m_prev = 0; m_ref = 0; m_val = 0; pq.delete(); hq.delete();
      end else begin
         clr  = !det_en || np_we;
         lat  = 0;
         neff = (m_np == 0) ? 1 : m_np;
         if (tick) begin
            m_tick++;
            if (!clr) begin
               if (ir && !m_prev) begin
                  if (m_ref) begin
                     pq.push_back((m_tick - m_last > 127) ? 127 : m_tick - m_last);
                     hq.push_back((m_hi > 127) ? 127 : m_hi);
                     if (pq.size() == neff) begin
                        sp = 0; sh = 0;
                        foreach (pq[k]) begin sp += pq[k]; sh += hq[k]; end
                        m_prd = sp / neff; m_hprd = sh / neff; lat = 1;
                        pq.delete(); hq.delete();
                     end
                  end
                  m_ref = 1; m_last = m_tick; m_hi = 1;
               end else if (ir) m_hi++;
            end
            m_prev = ir;
         end
         if (clr) begin m_ref = 0; pq.delete(); hq.delete(); end
         if (np_we) m_np = np_wdata;
         if (lat) m_val = 1; else if (rd_prd) m_val = 0;
      end
   end

   // Clock-by-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "model prd", prd, {m_val, 7'(m_prd)});
         chk(cur_req, "model hprd", hprd, 8'(m_hprd));
         chk(cur_req, "model np", np_q, 8'(m_np));
      end
   end

   // One tick period: tick cycle plus two idle cycles (glitched if enabled)
   task automatic step(bit lvl);
      tick = 1'b1; ir = lvl;
      @(posedge clk); #1;
      tick = 1'b0; ir = glitch ? ~lvl : lvl;
      @(posedge clk); #1;
      ir = lvl;
      @(posedge clk); #1;
   endtask

   task automatic carrier(int p, int h);
      repeat (h) step(1'b1);
      repeat (p - h) step(1'b0);
   endtask

   task automatic write_np(logic [7:0] v);
      np_we = 1'b1; np_wdata = v;
      @(posedge clk); #1;
      np_we = 1'b0;
   endtask

   task automatic expect_out(string req, int ep, int eh);
      @(negedge clk);
      chk(req, "prd", prd, ep);
      chk(req, "hprd", hprd, eh);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset prd", prd, 8'h00);
      chk("R1", "reset hprd", hprd, 8'h00);
      chk("R1", "reset np", np_q, 8'h63);
      @(posedge clk); #1;

      // R2: exact single-cycle capture
      cur_req = "R2"; det_en = 1'b1;
      write_np(8'd1);
      step(1'b0);
      carrier(10, 4); carrier(10, 4); step(1'b1);
      expect_out("R2", 8'h8A, 8'h04);
      step(1'b0);

      // R7: read clears only the flag
      cur_req = "R7";
      rd_prd = 1'b1; @(posedge clk); #1; rd_prd = 1'b0;
      expect_out("R7", 8'h0A, 8'h04);

      // R3 with R10: fractional four-cycle average, glitches between ticks
      cur_req = "R3"; glitch = 1'b1;
      write_np(8'd4);
      step(1'b0); step(1'b0);
      carrier(10, 5); carrier(11, 5); carrier(12, 6); carrier(13, 6); step(1'b1);
      expect_out("R3", 8'h8B, 8'h05);
      chk("R10", "glitch-free hprd", hprd, 8'h05);
      glitch = 1'b0;
      step(1'b0);

      // R4: zero configuration behaves as one
      cur_req = "R4";
      write_np(8'd0);
      step(1'b0);
      carrier(20, 7); step(1'b1);
      expect_out("R4", 8'h94, 8'h07);
      step(1'b0);

      // R5: saturation of long cycles
      cur_req = "R5";
      write_np(8'd1);
      step(1'b0);
      carrier(200, 150); step(1'b1);
      expect_out("R5", 8'hFF, 8'h7F);
      step(1'b0);

      // R7: latch and read strobe in the same cycle
      cur_req = "R7";
      write_np(8'd1);
      rd_prd = 1'b1;
      step(1'b0);
      carrier(9, 3);
      tick = 1'b1; ir = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
      @(negedge clk);
      chk("R7", "latch wins over read", prd, 8'h89);
      @(posedge clk); #1; rd_prd = 1'b0;
      @(negedge clk);
      chk("R7", "read clears next", prd, 8'h09);
      @(posedge clk); #1;
      step(1'b1); step(1'b0);

      // R8: disabled detection holds results, restart on enable
      cur_req = "R8";
      det_en = 1'b0;
      step(1'b0);
      carrier(30, 10); carrier(30, 10); step(1'b1);
      expect_out("R8", 8'h09, 8'h03);
      det_en = 1'b1;
      step(1'b0);
      carrier(6, 2); step(1'b1);
      expect_out("R8", 8'h86, 8'h02);
      step(1'b0);

      // R9: configuration write discards the partial accumulation
      cur_req = "R9";
      write_np(8'd3);
      step(1'b0);
      carrier(30, 10); carrier(30, 10);
      write_np(8'd2);
      carrier(8, 4); carrier(8, 4); carrier(8, 4); step(1'b1);
      expect_out("R9", 8'h88, 8'h04);
      chk("R6", "valid period nonzero", (prd[6:0] != 0) ? 1 : 0, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule